// File: doc/BRIEF.md
# Burst Splitting Master Adapter

This block connects a compute kernel to an AXI4 memory master port. The kernel posts read and write requests, each a start address and a beat count of any size. The adapter breaks each request into legal incrementing AXI4 bursts. A burst is cut wherever it reaches the configured maximum length, and wherever the next address would pass into a new 4096-byte page.

Read bursts go out as soon as a request arrives, provided the in-flight limit allows it. Write data from the kernel is staged in an internal buffer. Each write burst's address is released only once data for it is waiting. A run-time mode pin can tighten this rule so that a write address waits until every beat of its burst is buffered. That costs write latency but means no write burst can stall the bus halfway through.

Separate counters limit the number of bursts in flight on each direction. On the read side, the kernel sees one continuous stream per request, with its last flag only at the true end of that request. On the write side, the kernel sees one acknowledgement per request, which also carries any error.

Top module: `burst_split_adapter`

## Requirements
- R1: Each emitted burst has between 1 and MAX_BURST beats. The length field equals the beat count minus one, the burst type is INCR (2'b01), the size field is log2 of the bus width in bytes, and successive bursts of one request cover its addresses in ascending order with no gap.
- R2: No burst crosses a 4096-byte boundary. The beat count of each burst is the smallest of three values: the beats remaining in the request, MAX_BURST, and the beats left before the next 4096-byte boundary.
- R3: Read bursts in flight, counted from the AR handshake to the R beat that carries the last flag, never exceed MAX_OUT. Once that limit is reached, AR issue stalls until a burst completes.
- R4: A read address is presented in the cycle after the request is accepted if the in-flight limit allows it, and its address and length stay unchanged while the slave does not accept it.
- R5: Write data beats leave in the order the kernel supplied them, and the last flag on W is set on the final beat of every emitted burst and on no other beat.
- R6: With the hold pin low, a write address is released only when at least one beat is buffered and all W beats of the previous burst have been sent. Write bursts in flight, counted from the AW handshake to the B handshake, never exceed MAX_OUT.
- R7: With the hold pin high, a write address is released only when every beat of that burst is already in the buffer.
- R8: Each write request produces exactly one acknowledgement pulse, after the B responses of all its bursts. The error flag is set if any of those responses had bit 1 of the response code set (SLVERR or DECERR).
- R9: Read beats reach the kernel in order. The kernel last flag is set only on the final beat of the original request. The per-beat error flag is bit 1 of that beat's response code.
- R10: After reset, no address or write-data valid is asserted, no acknowledgement is pending, and all kernel-side ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_wr_addr | input | 1 | 1: write address waits for the full burst's data |
| rq_valid | input | 1 | Kernel read request valid |
| rq_ready | output | 1 | Read request accepted |
| rq_addr | input | ADDR_W | Read start byte address, bus-width aligned |
| rq_len | input | LEN_W | Read length in beats (nonzero) |
| rd_valid | output | 1 | Read beat valid to kernel |
| rd_ready | input | 1 | Kernel accepts read beat |
| rd_data | output | DATA_W | Read beat data |
| rd_last | output | 1 | Final beat of the kernel request |
| rd_err | output | 1 | Beat returned an error response |
| wq_valid | input | 1 | Kernel write request valid |
| wq_ready | output | 1 | Write request accepted |
| wq_addr | input | ADDR_W | Write start byte address, bus-width aligned |
| wq_len | input | LEN_W | Write length in beats (nonzero) |
| wd_valid | input | 1 | Kernel write beat valid |
| wd_ready | output | 1 | Write buffer has room |
| wd_data | input | DATA_W | Kernel write beat |
| wack_valid | output | 1 | One-cycle write completion pulse |
| wack_err | output | 1 | Some burst of that request failed |
| m_araddr | output | ADDR_W | AR address |
| m_arlen | output | 8 | AR length (beats minus one) |
| m_arsize | output | 3 | AR size |
| m_arburst | output | 2 | AR burst type |
| m_arvalid | output | 1 | AR valid |
| m_arready | input | 1 | AR ready |
| m_rdata | input | DATA_W | R data |
| m_rresp | input | 2 | R response |
| m_rlast | input | 1 | R last |
| m_rvalid | input | 1 | R valid |
| m_rready | output | 1 | R ready |
| m_awaddr | output | ADDR_W | AW address |
| m_awlen | output | 8 | AW length (beats minus one) |
| m_awsize | output | 3 | AW size |
| m_awburst | output | 2 | AW burst type |
| m_awvalid | output | 1 | AW valid |
| m_awready | input | 1 | AW ready |
| m_wdata | output | DATA_W | W data |
| m_wstrb | output | DATA_W/8 | W byte strobes, all set |
| m_wlast | output | 1 | W last |
| m_wvalid | output | 1 | W valid |
| m_wready | input | 1 | W ready |
| m_bresp | input | 2 | B response |
| m_bvalid | input | 1 | B valid |
| m_bready | output | 1 | B ready, always set |

## Verification
The hardest states to reach are those where both in-flight counters sit at MAX_OUT while more split bursts are waiting. Reaching them needs a slave that stops returning R data and B responses while the kernel keeps requesting. The stimulus gets there by running rounds in which the modelled slave withholds every response for most of each 300-cycle window. Long and page-straddling requests are queued during those windows, and the bench records the peak in-flight count it observed. The hold mode is run both with and without these stalls, so that AW release against buffer fill is checked while the kernel supplies write data with random gaps.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam int PAGE_BYTES = 4096;
endpackage

// File: rtl/bsa_fifo.sv
module bsa_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  // R3 R6: queues sized by the in-flight limit are never overrun
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst) push |-> !full);
  // R5 R9: pops only happen with data present
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/bsa_splitter.sv
module bsa_splitter import bsa_pkg::*; #(
  parameter int AW        = 32,
  parameter int LW        = 16,
  parameter int MAX_BURST = 16,
  parameter int BYTES     = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          bst_valid,
  output logic [AW-1:0] bst_addr,
  output logic [8:0]    bst_beats,
  output logic          bst_final,
  input  logic          bst_take
);
  localparam int SH = $clog2(BYTES);

  logic          busy;
  logic [AW-1:0] cur;
  logic [LW-1:0] left;
  logic [31:0]   to_edge, lim;

  always_comb begin
    to_edge = (32'(PAGE_BYTES) - 32'(cur[11:0])) >> SH;
    lim     = 32'(left);
    if (lim > 32'(MAX_BURST)) lim = 32'(MAX_BURST);
    if (lim > to_edge)        lim = to_edge;
  end

  assign req_ready = !busy;
  assign bst_valid = busy;
  assign bst_addr  = cur;
  assign bst_beats = lim[8:0];
  assign bst_final = (32'(left) == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cur  <= '0;
      left <= '0;
    end else if (!busy) begin
      if (req_valid && req_len != '0) begin
        busy <= 1'b1;
        cur  <= req_addr;
        left <= req_len;
      end
    end else if (bst_take) begin
      cur  <= cur + (AW'(lim) << SH);
      left <= left - LW'(lim);
      if (bst_final) busy <= 1'b0;
    end
  end

  // R1: an offered burst always carries at least one beat
  nonzero_chk: assert property (@(posedge clk) disable iff (rst) bst_valid |-> bst_beats != 9'd0);
endmodule

// File: rtl/burst_split_adapter.sv
module burst_split_adapter import bsa_pkg::*; #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_BURST  = 16,
  parameter int MAX_OUT    = 4,
  parameter int WBUF_DEPTH = MAX_BURST
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hold_wr_addr,
  input  logic                rq_valid,
  output logic                rq_ready,
  input  logic [ADDR_W-1:0]   rq_addr,
  input  logic [LEN_W-1:0]    rq_len,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_last,
  output logic                rd_err,
  input  logic                wq_valid,
  output logic                wq_ready,
  input  logic [ADDR_W-1:0]   wq_addr,
  input  logic [LEN_W-1:0]    wq_len,
  input  logic                wd_valid,
  output logic                wd_ready,
  input  logic [DATA_W-1:0]   wd_data,
  output logic                wack_valid,
  output logic                wack_err,
  output logic [ADDR_W-1:0]   m_araddr,
  output logic [7:0]          m_arlen,
  output logic [2:0]          m_arsize,
  output logic [1:0]          m_arburst,
  output logic                m_arvalid,
  input  logic                m_arready,
  input  logic [DATA_W-1:0]   m_rdata,
  input  logic [1:0]          m_rresp,
  input  logic                m_rlast,
  input  logic                m_rvalid,
  output logic                m_rready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  output logic                m_wvalid,
  input  logic                m_wready,
  input  logic [1:0]          m_bresp,
  input  logic                m_bvalid,
  output logic                m_bready
);
  localparam int BYTES = DATA_W / 8;
  localparam int SH    = $clog2(BYTES);
  localparam int OW    = $clog2(MAX_OUT + 1);
  localparam int CW    = $clog2(WBUF_DEPTH + 1);
  localparam int FW    = $clog2(MAX_OUT + 1);

  // ---------------- read path ----------------
  logic              rs_valid, rs_final, ar_hs, r_hs, r_end, rflag_head;
  logic [ADDR_W-1:0] rs_addr;
  logic [8:0]        rs_beats;
  logic [OW-1:0]     rd_out;
  logic              rflag_full, rflag_empty;
  logic [FW-1:0]     rflag_cnt;

  bsa_splitter #(.AW(ADDR_W), .LW(LEN_W), .MAX_BURST(MAX_BURST), .BYTES(BYTES)) u_rsplit (
    .clk(clk), .rst(rst), .req_valid(rq_valid), .req_ready(rq_ready),
    .req_addr(rq_addr), .req_len(rq_len), .bst_valid(rs_valid), .bst_addr(rs_addr),
    .bst_beats(rs_beats), .bst_final(rs_final), .bst_take(ar_hs));

  assign m_arvalid = rs_valid && (rd_out < OW'(MAX_OUT));
  assign m_araddr  = rs_addr;
  assign m_arlen   = 8'(rs_beats - 9'd1);
  assign m_arsize  = 3'(SH);
  assign m_arburst = BURST_INCR;
  assign ar_hs     = m_arvalid && m_arready;
  assign r_hs      = m_rvalid && rd_ready;
  assign r_end     = r_hs && m_rlast;

  bsa_fifo #(.W(1), .DEPTH(MAX_OUT)) u_rflag (
    .clk(clk), .rst(rst), .push(ar_hs), .din(rs_final), .pop(r_end),
    .dout(rflag_head), .full(rflag_full), .empty(rflag_empty), .count(rflag_cnt));

  assign m_rready = rd_ready;
  assign rd_valid = m_rvalid;
  assign rd_data  = m_rdata;
  assign rd_last  = m_rlast && rflag_head;
  assign rd_err   = m_rresp[1];

  always_ff @(posedge clk) begin
    if (rst) rd_out <= '0;
    else     rd_out <= rd_out + OW'(ar_hs) - OW'(r_end);
  end

  // ---------------- write path ----------------
  logic              ws_valid, ws_final, aw_hs, w_hs, b_hs, data_ok, bflag_head, err_acc;
  logic [ADDR_W-1:0] ws_addr;
  logic [8:0]        ws_beats, w_left;
  logic [OW-1:0]     wr_out;
  logic              wbuf_full, wbuf_empty, bflag_full, bflag_empty;
  logic [CW-1:0]     wcount;
  logic [FW-1:0]     bflag_cnt;

  bsa_splitter #(.AW(ADDR_W), .LW(LEN_W), .MAX_BURST(MAX_BURST), .BYTES(BYTES)) u_wsplit (
    .clk(clk), .rst(rst), .req_valid(wq_valid), .req_ready(wq_ready),
    .req_addr(wq_addr), .req_len(wq_len), .bst_valid(ws_valid), .bst_addr(ws_addr),
    .bst_beats(ws_beats), .bst_final(ws_final), .bst_take(aw_hs));

  bsa_fifo #(.W(DATA_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
    .clk(clk), .rst(rst), .push(wd_valid && !wbuf_full), .din(wd_data), .pop(w_hs),
    .dout(m_wdata), .full(wbuf_full), .empty(wbuf_empty), .count(wcount));

  assign wd_ready  = !wbuf_full;
  assign data_ok   = hold_wr_addr ? (32'(wcount) >= 32'(ws_beats)) : (wcount != '0);
  assign m_awvalid = ws_valid && (wr_out < OW'(MAX_OUT)) && (w_left == 9'd0) && data_ok;
  assign m_awaddr  = ws_addr;
  assign m_awlen   = 8'(ws_beats - 9'd1);
  assign m_awsize  = 3'(SH);
  assign m_awburst = BURST_INCR;
  assign aw_hs     = m_awvalid && m_awready;
  assign m_wvalid  = (w_left != 9'd0) && !wbuf_empty;
  assign m_wlast   = (w_left == 9'd1);
  assign m_wstrb   = '1;
  assign w_hs      = m_wvalid && m_wready;
  assign m_bready  = 1'b1;
  assign b_hs      = m_bvalid;

  bsa_fifo #(.W(1), .DEPTH(MAX_OUT)) u_bflag (
    .clk(clk), .rst(rst), .push(aw_hs), .din(ws_final), .pop(b_hs),
    .dout(bflag_head), .full(bflag_full), .empty(bflag_empty), .count(bflag_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      w_left     <= '0;
      wr_out     <= '0;
      err_acc    <= 1'b0;
      wack_valid <= 1'b0;
      wack_err   <= 1'b0;
    end else begin
      if (aw_hs)     w_left <= ws_beats;
      else if (w_hs) w_left <= w_left - 9'd1;
      wr_out     <= wr_out + OW'(aw_hs) - OW'(b_hs);
      wack_valid <= b_hs && bflag_head;
      if (b_hs) begin
        wack_err <= err_acc | m_bresp[1];
        err_acc  <= bflag_head ? 1'b0 : (err_acc | m_bresp[1]);
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{m_rresp[0], m_bresp[0], rflag_full, rflag_empty, rflag_cnt,
                         bflag_full, bflag_empty, bflag_cnt};

  // ---------------- assertions ----------------
  // R1
  ar_len_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> (32'(m_arlen) < 32'(MAX_BURST)));
  // R2
  ar_page_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid |-> (32'(m_araddr[11:0]) + ((32'(m_arlen) + 1) << SH)) <= 32'(PAGE_BYTES));
  // R2
  aw_page_chk: assert property (@(posedge clk) disable iff (rst)
    m_awvalid |-> (32'(m_awaddr[11:0]) + ((32'(m_awlen) + 1) << SH)) <= 32'(PAGE_BYTES));
  // R3
  rd_cap_chk: assert property (@(posedge clk) disable iff (rst) rd_out <= OW'(MAX_OUT));
  // R6
  wr_cap_chk: assert property (@(posedge clk) disable iff (rst) wr_out <= OW'(MAX_OUT));
  // R4
  ar_hold_chk: assert property (@(posedge clk) disable iff (rst)
    m_arvalid && !m_arready |=> m_arvalid && $stable(m_araddr) && $stable(m_arlen));
  // R7
  full_burst_chk: assert property (@(posedge clk) disable iff (rst)
    m_awvalid && hold_wr_addr |-> 32'(wcount) >= 32'(m_awlen) + 1);
  // R8
  ack_after_b_chk: assert property (@(posedge clk) disable iff (rst)
    wack_valid |-> $past(m_bvalid));
endmodule

// File: tb/burst_split_adapter_bench.sv
`timescale 1ns/1ps
module burst_split_adapter_bench;
  localparam int AWD = 32, DW = 32, LW = 16, MB = 16, MO = 4;
  localparam int WD_LIMIT = 150000;

  typedef struct { logic [31:0] a; int n; } bst_t;
  typedef struct { logic [31:0] d; bit last; bit err; } rbeat_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, hold_wr_addr;
  logic rq_valid, rq_ready, rd_valid, rd_ready, rd_last, rd_err;
  logic [31:0] rq_addr, wq_addr, rd_data, wd_data;
  logic [15:0] rq_len, wq_len;
  logic wq_valid, wq_ready, wd_valid, wd_ready, wack_valid, wack_err;
  logic [31:0] m_araddr, m_awaddr, m_rdata, m_wdata;
  logic [7:0]  m_arlen, m_awlen;
  logic [2:0]  m_arsize, m_awsize;
  logic [1:0]  m_arburst, m_awburst, m_rresp, m_bresp;
  logic m_arvalid, m_arready, m_rlast, m_rvalid, m_rready;
  logic m_awvalid, m_awready, m_wlast, m_wvalid, m_wready, m_bvalid, m_bready;
  logic [3:0] m_wstrb;

  burst_split_adapter #(.ADDR_W(AWD), .DATA_W(DW), .LEN_W(LW), .MAX_BURST(MB), .MAX_OUT(MO)) u_burst_split_adapter (
    .clk(clk), .rst(rst), .hold_wr_addr(hold_wr_addr),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr), .rq_len(rq_len),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_last(rd_last), .rd_err(rd_err),
    .wq_valid(wq_valid), .wq_ready(wq_ready), .wq_addr(wq_addr), .wq_len(wq_len),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .wack_valid(wack_valid), .wack_err(wack_err),
    .m_araddr(m_araddr), .m_arlen(m_arlen), .m_arsize(m_arsize), .m_arburst(m_arburst),
    .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rlast(m_rlast), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .m_awaddr(m_awaddr), .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready));

  int checks = 0, fails = 0, cyc = 0;
  int rd_todo = 0, wr_todo = 0, rd_infl = 0, wr_infl = 0, peak_rd = 0, peak_wr = 0;
  int s_r_idx = 0, buffered = 0;
  bit holdoff = 0, hold = 0;
  bit rq_hs = 0, wq_hs = 0, r_hs = 0, prev_rq_hs = 0;
  bit prev_ar_wait = 0;
  logic [31:0] prev_araddr;
  logic [7:0]  prev_arlen;

  bst_t   exp_ar[$], exp_aw[$], s_ar[$], s_aw[$];
  rbeat_t exp_rd[$];
  bit     exp_wl[$], exp_ack[$], s_b[$];
  logic [31:0] exp_wd[$], kd[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] rmem(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  function automatic logic [31:0] gen_addr();
    case ($urandom_range(0, 2))
      0:       return 32'($urandom_range(0, 16383)) * 4;
      1:       return 32'($urandom_range(1, 15)) * 4096 - 32'($urandom_range(1, 24)) * 4;
      default: return 32'($urandom_range(0, 15)) * 4096;
    endcase
  endfunction

  function automatic logic [15:0] gen_len();
    int r;
    r = $urandom_range(0, 9);
    if (r < 6) return 16'($urandom_range(1, 20));
    if (r < 9) return 16'($urandom_range(21, 80));
    return 16'($urandom_range(200, 300));
  endfunction

  // Reference split: smallest of remaining, maximum, beats to page edge
  task automatic split(input logic [31:0] a0, input int n0, input bit is_rd);
    logic [31:0] a;
    int n, b, edge_b;
    bit err;
    a = a0; n = n0; err = 0;
    while (n > 0) begin
      edge_b = (4096 - int'(a[11:0])) / 4;
      b = n;
      if (b > MB) b = MB;
      if (b > edge_b) b = edge_b;
      if (is_rd) begin
        exp_ar.push_back('{a, b});
        for (int i = 0; i < b; i++)
          exp_rd.push_back('{rmem(a + 32'(i * 4)), (n == b) && (i == b - 1), a[15]});
      end else begin
        exp_aw.push_back('{a, b});
        for (int i = 0; i < b; i++) exp_wl.push_back(i == b - 1);
        err = err | a[15];
      end
      a = a + 32'(b * 4);
      n = n - b;
    end
    if (!is_rd) exp_ack.push_back(err);
  endtask

  task automatic step();
    bit ar_hs, aw_hs, w_hs, b_hs, wd_hs;
    logic [31:0] ra;
    @(negedge clk);
    cyc++;
    // ---- drive ----
    if (rq_hs) rq_valid = 0;
    if (wq_hs) wq_valid = 0;
    if (r_hs)  m_rvalid = 0;
    m_bvalid = 0;
    if (!rq_valid && rd_todo > 0 && $urandom_range(0, 3) != 0) begin
      rq_addr = gen_addr(); rq_len = gen_len(); rq_valid = 1; rd_todo--;
    end
    if (!wq_valid && wr_todo > 0 && $urandom_range(0, 3) != 0) begin
      wq_addr = gen_addr(); wq_len = gen_len(); wq_valid = 1; wr_todo--;
      for (int i = 0; i < int'(wq_len); i++) kd.push_back($urandom);
    end
    wd_valid  = (kd.size() != 0) && ($urandom_range(0, 3) != 0);
    wd_data   = (kd.size() != 0) ? kd[0] : 32'h0;
    rd_ready  = $urandom_range(0, 3) != 0;
    m_arready = $urandom_range(0, 2) != 0;
    m_awready = $urandom_range(0, 2) != 0;
    m_wready  = $urandom_range(0, 3) != 0;
    hold = holdoff && ((cyc % 300) < 200);
    if (!m_rvalid && s_ar.size() != 0 && !hold && $urandom_range(0, 3) != 0) m_rvalid = 1;
    if (m_rvalid) begin
      ra = s_ar[0].a + 32'(s_r_idx * 4);
      m_rdata = rmem(ra);
      m_rlast = (s_r_idx == s_ar[0].n - 1);
      m_rresp = ra[15] ? 2'b10 : 2'b00;
    end
    if (s_b.size() != 0 && !hold && $urandom_range(0, 2) != 0) begin
      m_bvalid = 1;
      m_bresp  = s_b[0] ? 2'b10 : 2'b00;
    end
    #0.5;
    // ---- observe ----
    ar_hs = m_arvalid && m_arready;
    aw_hs = m_awvalid && m_awready;
    w_hs  = m_wvalid && m_wready;
    b_hs  = m_bvalid && m_bready;
    r_hs  = m_rvalid && rd_ready;
    wd_hs = wd_valid && wd_ready;
    rq_hs = rq_valid && rq_ready;
    wq_hs = wq_valid && wq_ready;

    if (prev_rq_hs && rd_infl < MO)
      chk(m_arvalid, "R4 AR presented right after accept", m_arvalid, 1);
    if (prev_ar_wait)
      chk(m_arvalid && m_araddr == prev_araddr && m_arlen == prev_arlen,
          "R4 AR held stable", m_araddr, prev_araddr);
    prev_ar_wait = m_arvalid && !m_arready;
    prev_araddr  = m_araddr;
    prev_arlen   = m_arlen;
    prev_rq_hs   = rq_hs;

    if (ar_hs) begin
      if (exp_ar.size() == 0) chk(0, "R1 unexpected AR", m_araddr, 0);
      else begin
        chk(m_araddr == exp_ar[0].a, "R1 AR address", m_araddr, exp_ar[0].a);
        chk(int'(m_arlen) + 1 == exp_ar[0].n, "R2 AR beats", int'(m_arlen) + 1, exp_ar[0].n);
        chk(m_arburst == 2'b01 && m_arsize == 3'd2, "R1 AR type/size",
            {m_arburst, m_arsize}, 5'b01010);
        void'(exp_ar.pop_front());
      end
      chk(rd_infl < MO, "R3 read in-flight limit", rd_infl, MO - 1);
      s_ar.push_back('{m_araddr, int'(m_arlen) + 1});
      rd_infl++;
      if (rd_infl > peak_rd) peak_rd = rd_infl;
    end
    if (r_hs) begin
      chk(rd_valid, "R9 rd_valid follows R", rd_valid, 1);
      if (exp_rd.size() == 0) chk(0, "R9 unexpected read beat", rd_data, 0);
      else begin
        chk(rd_data == exp_rd[0].d, "R9 read data", rd_data, exp_rd[0].d);
        chk(rd_last == exp_rd[0].last, "R9 read last", rd_last, exp_rd[0].last);
        chk(rd_err == exp_rd[0].err, "R9 read error", rd_err, exp_rd[0].err);
        void'(exp_rd.pop_front());
      end
      if (m_rlast) begin
        void'(s_ar.pop_front()); s_r_idx = 0; rd_infl--;
      end else s_r_idx++;
    end
    if (rq_hs) split(rq_addr, int'(rq_len), 1);
    if (wq_hs) split(wq_addr, int'(wq_len), 0);

    if (aw_hs) begin
      if (exp_aw.size() == 0) chk(0, "R1 unexpected AW", m_awaddr, 0);
      else begin
        chk(m_awaddr == exp_aw[0].a, "R1 AW address", m_awaddr, exp_aw[0].a);
        chk(int'(m_awlen) + 1 == exp_aw[0].n, "R2 AW beats", int'(m_awlen) + 1, exp_aw[0].n);
        chk(m_awburst == 2'b01 && m_awsize == 3'd2, "R1 AW type/size",
            {m_awburst, m_awsize}, 5'b01010);
        void'(exp_aw.pop_front());
      end
      if (hold_wr_addr)
        chk(buffered >= int'(m_awlen) + 1, "R7 full burst buffered", buffered, int'(m_awlen) + 1);
      else
        chk(buffered >= 1, "R6 data present at AW", buffered, 1);
      chk(s_aw.size() == 0, "R6 previous W finished", s_aw.size(), 0);
      chk(wr_infl < MO, "R6 write in-flight limit", wr_infl, MO - 1);
      s_aw.push_back('{m_awaddr, int'(m_awlen) + 1});
      wr_infl++;
      if (wr_infl > peak_wr) peak_wr = wr_infl;
    end
    if (w_hs) begin
      if (exp_wd.size() == 0 || exp_wl.size() == 0 || s_aw.size() == 0)
        chk(0, "R5 unexpected W beat", m_wdata, 0);
      else begin
        chk(m_wdata == exp_wd[0], "R5 W data order", m_wdata, exp_wd[0]);
        chk(m_wlast == exp_wl[0], "R5 W last", m_wlast, exp_wl[0]);
        void'(exp_wd.pop_front());
        void'(exp_wl.pop_front());
        if (m_wlast) begin
          s_b.push_back(s_aw[0].a[15]);
          void'(s_aw.pop_front());
        end
      end
      buffered--;
    end
    if (wd_hs) begin
      exp_wd.push_back(wd_data);
      void'(kd.pop_front());
      buffered++;
    end
    if (b_hs) begin
      void'(s_b.pop_front());
      wr_infl--;
    end
    if (wack_valid) begin
      if (exp_ack.size() == 0) chk(0, "R8 unexpected ack", 1, 0);
      else begin
        chk(wack_err == exp_ack[0], "R8 ack error flag", wack_err, exp_ack[0]);
        void'(exp_ack.pop_front());
      end
    end
  endtask

  function automatic bit idle();
    return rd_todo == 0 && wr_todo == 0 && !rq_valid && !wq_valid && kd.size() == 0 &&
           exp_ar.size() == 0 && exp_rd.size() == 0 && exp_aw.size() == 0 &&
           exp_wl.size() == 0 && exp_ack.size() == 0 && s_ar.size() == 0 &&
           s_aw.size() == 0 && s_b.size() == 0;
  endfunction

  task automatic run_round(input int nr, input int nw, input bit cons, input bit stall);
    @(negedge clk);
    hold_wr_addr = cons;
    holdoff = stall;
    rd_todo = nr;
    wr_todo = nw;
    while (!idle() && cyc < WD_LIMIT) step();
    repeat (3) step();
  endtask

  initial begin
    rst = 1; hold_wr_addr = 0;
    rq_valid = 0; rq_addr = 0; rq_len = 0; rd_ready = 0;
    wq_valid = 0; wq_addr = 0; wq_len = 0; wd_valid = 0; wd_data = 0;
    m_arready = 0; m_awready = 0; m_wready = 0;
    m_rvalid = 0; m_rdata = 0; m_rresp = 0; m_rlast = 0; m_bvalid = 0; m_bresp = 0;
    repeat (5) @(negedge clk);
    rst = 0;
    #0.5;
    // R10 reset state
    chk(!m_arvalid && !m_awvalid && !m_wvalid, "R10 no valid after reset",
        {m_arvalid, m_awvalid, m_wvalid}, 0);
    chk(!wack_valid, "R10 no ack after reset", wack_valid, 0);
    chk(rq_ready && wq_ready && wd_ready, "R10 kernel readies after reset",
        {rq_ready, wq_ready, wd_ready}, 3'b111);

    run_round(25, 25, 0, 0);
    run_round(30, 30, 0, 1);
    run_round(25, 25, 1, 0);
    run_round(20, 20, 1, 1);

    if (cyc >= WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    chk(idle(), "R8 all traffic and acks drained", exp_ack.size(), 0);
    // R3: the stalled rounds must have driven the read side to its limit
    chk(peak_rd == MO, "R3 read limit reached", peak_rd, MO);
    // R6: same for the write side
    chk(peak_wr == MO, "R6 write limit reached", peak_wr, MO);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule